// File: doc/BRIEF.md
# Watchdog Timer with Escalating Time-out Actions

The block counts ticks of a slow, independent time base. The tick arrives as a one-cycle enable that is already synchronous to the system clock. Software must restart the count with a kick strobe before a selectable time-out runs out. When the count runs out, the block takes one of three actions:

- it raises a pending interrupt;
- it drives a fixed-width system reset pulse;
- it raises an interrupt first and drives a reset on the following time-out.

A control register holds two enables and a four-bit period selector. An always-on lock input pins the block into reset-only operation. A sticky status flag records that a watchdog reset took place. This flag lives through the watchdog's own reset pulse. It is lost only on power-on reset or when software writes zero to it.

At the defaults the shortest period is 2048 ticks and the longest is 1,048,576 ticks. With a 128 kHz time base this spans about 16 ms to 8 s.

Top module: `watchdog_unit`

## Requirements
- R1: With at least one enable active, a time-out occurs on the tick that completes 2^(BASE_LOG + code) ticks after the last restart, where code is the period selector. One tick earlier, no action has been taken.
- R2: Selector codes above NUM_CODES-1 give the same period as code NUM_CODES-1.
- R3: A kick sets the count back to zero. A kick in the same cycle as the terminal tick prevents that time-out, and a full period is then needed again.
- R4: With only the interrupt enable set, a time-out sets `irq_pend` one cycle after the expiring tick and causes no reset. `irq_pend` stays set until a cycle with `irq_clr` high.
- R5: With only the reset enable set, a time-out drives `wd_reset` high for exactly RST_PULSE cycles, starting the cycle after the expiring tick. Ticks are not counted during the pulse, and the count restarts at zero after it.
- R6: With both enables set, a time-out sets `irq_pend` and the hardware clears the interrupt enable (read back 0). The next time-out then drives a reset. Software may set the interrupt enable again to restore the interrupt-first behaviour.
- R7: With both enables at 0, the count does not advance, and no interrupt or reset is produced however many ticks arrive.
- R8: While `lock` is high, the enables read as reset=1 and interrupt=0, a time-out drives a reset, and control writes leave the stored enables unchanged. The selector remains writable.
- R9: `rst_flag` is set when a watchdog reset starts and stays set through that pulse. A cycle with `flag_we` high and `flag_wdata` 0 clears it, `flag_wdata` 1 has no effect, and power-on reset clears it.
- R10: After power-on reset, both enables, the selector, `irq_pend`, `wd_reset` and `rst_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| tick | input | 1 | One-cycle enable from the slow time base |
| kick | input | 1 | Restart strobe from software |
| ctrl_we | input | 1 | Control register write strobe |
| wr_irq_en | input | 1 | Interrupt enable value to write |
| wr_rst_en | input | 1 | Reset enable value to write |
| wr_psel | input | 4 | Period selector value to write |
| irq_clr | input | 1 | Write-one strobe that clears the pending interrupt |
| flag_we | input | 1 | Reset-cause flag write strobe |
| flag_wdata | input | 1 | Value written to the flag (only 0 acts) |
| lock | input | 1 | Always-on lock, forces reset-only operation |
| irq_en | output | 1 | Effective interrupt enable |
| rst_en | output | 1 | Effective reset enable |
| psel | output | 4 | Stored period selector |
| irq_pend | output | 1 | Pending watchdog interrupt |
| wd_reset | output | 1 | System reset pulse |
| rst_flag | output | 1 | Sticky watchdog reset cause flag |

## Verification
The expiring tick is registered once, at the edge where it is sampled. As a result, `irq_pend`, the cleared interrupt enable and the first cycle of `wd_reset` are all visible one cycle after that tick. A control write appears on the read-back outputs one cycle after its strobe. The bench drives every input on the falling edge and applies each tick as one high cycle followed by one low cycle. It therefore samples results on the falling edge right after the last tick of a period, and it samples the terminal-minus-one state one tick earlier. The reset pulse width is found by sampling `wd_reset` on consecutive falling edges from the first cycle after expiry and counting the high samples.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int PSEL_W = 4;

  typedef struct packed {
    logic              irq_en;
    logic              rst_en;
    logic [PSEL_W-1:0] psel;
  } wdog_ctrl_t;

  typedef enum logic [1:0] {
    WD_OFF  = 2'b00,
    WD_RST  = 2'b01,
    WD_IRQ  = 2'b10,
    WD_BOTH = 2'b11
  } wdog_mode_e;

  function automatic wdog_mode_e mode_of(input wdog_ctrl_t c);
    return wdog_mode_e'({c.irq_en, c.rst_en});
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  wdog_ctrl_t wdata,
  input  logic       lock,
  input  logic       hw_clr_irq,
  output wdog_ctrl_t eff
);

  logic              irq_q, irq_d;
  logic              rst_q, rst_d;
  logic [PSEL_W-1:0] psel_q, psel_d;

  always_comb begin
    irq_d  = irq_q;
    rst_d  = rst_q;
    psel_d = psel_q;
    if (ctrl_we) begin
      psel_d = wdata.psel;
      if (!lock) begin
        irq_d = wdata.irq_en;
        rst_d = wdata.rst_en;
      end
    end else if (hw_clr_irq) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      rst_q  <= 1'b0;
      psel_q <= '0;
    end else begin
      irq_q  <= irq_d;
      rst_q  <= rst_d;
      psel_q <= psel_d;
    end
  end

  always_comb begin
    eff.irq_en = irq_q & ~lock;
    eff.rst_en = rst_q | lock;
    eff.psel   = psel_q;
  end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int BASE_LOG  = 11,
  parameter int NUM_CODES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              kick,
  input  logic              hold,
  input  logic              run,
  input  logic [PSEL_W-1:0] psel,
  output logic              expire
);

  localparam int MAX_CODE = NUM_CODES - 1;
  localparam int CNT_W    = BASE_LOG + MAX_CODE;

  logic [PSEL_W-1:0] code_sat;
  logic [CNT_W-1:0]  term;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              at_term;

  assign code_sat = (psel > PSEL_W'(MAX_CODE)) ? PSEL_W'(MAX_CODE) : psel;

  // terminal count: the low BASE_LOG+code bits set
  for (genvar i = 0; i < CNT_W; i++) begin : g_term
    assign term[i] = (i < BASE_LOG + int'(code_sat));
  end

  assign at_term = (cnt_q == term);
  assign expire  = tick & run & ~kick & ~hold & at_term;

  always_comb begin
    cnt_d = cnt_q;
    if (kick || hold || !run) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = at_term ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/wdog_events.sv
module wdog_events
  import wdog_pkg::*;
#(
  parameter int RST_PULSE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic irq_en,
  input  logic rst_en,
  input  logic irq_clr,
  input  logic flag_we,
  input  logic flag_wdata,
  output logic irq_pend,
  output logic wd_reset,
  output logic rst_flag,
  output logic hw_clr_irq
);

  localparam int PW = $clog2(RST_PULSE + 1);

  logic          take_irq, take_rst;
  logic          irq_q, irq_d;
  logic          flag_q, flag_d;
  logic [PW-1:0] rcnt_q, rcnt_d;

  assign take_irq   = expire & irq_en;
  assign take_rst   = expire & ~irq_en & rst_en;
  assign hw_clr_irq = take_irq & rst_en;

  always_comb begin
    irq_d = irq_q;
    if (take_irq)     irq_d = 1'b1;
    else if (irq_clr) irq_d = 1'b0;

    rcnt_d = rcnt_q;
    if (take_rst)           rcnt_d = PW'(RST_PULSE);
    else if (rcnt_q != '0)  rcnt_d = rcnt_q - 1'b1;

    flag_d = flag_q;
    if (take_rst)                   flag_d = 1'b1;
    else if (flag_we && !flag_wdata) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      flag_q <= 1'b0;
      rcnt_q <= '0;
    end else begin
      irq_q  <= irq_d;
      flag_q <= flag_d;
      rcnt_q <= rcnt_d;
    end
  end

  assign irq_pend = irq_q;
  assign rst_flag = flag_q;
  assign wd_reset = (rcnt_q != '0);

endmodule

// File: rtl/watchdog_unit.sv
module watchdog_unit
  import wdog_pkg::*;
#(
  parameter int BASE_LOG  = 11,
  parameter int NUM_CODES = 10,
  parameter int RST_PULSE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       kick,
  input  logic       ctrl_we,
  input  logic       wr_irq_en,
  input  logic       wr_rst_en,
  input  logic [3:0] wr_psel,
  input  logic       irq_clr,
  input  logic       flag_we,
  input  logic       flag_wdata,
  input  logic       lock,
  output logic       irq_en,
  output logic       rst_en,
  output logic [3:0] psel,
  output logic       irq_pend,
  output logic       wd_reset,
  output logic       rst_flag
);

  wdog_ctrl_t wdata, eff;
  logic       hw_clr_irq;
  logic       expire;
  logic       running;

  assign wdata.irq_en = wr_irq_en;
  assign wdata.rst_en = wr_rst_en;
  assign wdata.psel   = wr_psel;

  assign running = (mode_of(eff) != WD_OFF);

  wdog_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .wdata      (wdata),
    .lock       (lock),
    .hw_clr_irq (hw_clr_irq),
    .eff        (eff)
  );

  wdog_counter #(
    .BASE_LOG  (BASE_LOG),
    .NUM_CODES (NUM_CODES)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .kick   (kick),
    .hold   (wd_reset),
    .run    (running),
    .psel   (eff.psel),
    .expire (expire)
  );

  wdog_events #(
    .RST_PULSE (RST_PULSE)
  ) u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire     (expire),
    .irq_en     (eff.irq_en),
    .rst_en     (eff.rst_en),
    .irq_clr    (irq_clr),
    .flag_we    (flag_we),
    .flag_wdata (flag_wdata),
    .irq_pend   (irq_pend),
    .wd_reset   (wd_reset),
    .rst_flag   (rst_flag),
    .hw_clr_irq (hw_clr_irq)
  );

  assign irq_en = eff.irq_en;
  assign rst_en = eff.rst_en;
  assign psel   = eff.psel;

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int RST_PULSE = 4
) (
  input logic clk,
  input logic rst_n,
  input logic kick,
  input logic ctrl_we,
  input logic irq_clr,
  input logic lock,
  input logic irq_en,
  input logic rst_en,
  input logic irq_pend,
  input logic wd_reset,
  input logic rst_flag
);

  logic [7:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_len <= '0;
    else if (wd_reset) run_len <= run_len + 1'b1;
    else               run_len <= '0;
  end

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_reset) |-> (run_len == 8'(RST_PULSE)));

  // R9
  flag_on_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_reset) |-> rst_flag);

  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !irq_clr) |=> irq_pend);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !rst_en) |=> (!$rose(irq_pend) && !$rose(wd_reset)));

  // R3
  kick_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (!$rose(irq_pend) && !$rose(wd_reset)));

  // R8
  lock_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> !$rose(irq_pend));

  // R6
  combined_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && rst_en && !irq_pend && !ctrl_we) |=> (!irq_pend || !irq_en));

endmodule

bind watchdog_unit wdog_chk #(.RST_PULSE(RST_PULSE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .kick     (kick),
  .ctrl_we  (ctrl_we),
  .irq_clr  (irq_clr),
  .lock     (lock),
  .irq_en   (irq_en),
  .rst_en   (rst_en),
  .irq_pend (irq_pend),
  .wd_reset (wd_reset),
  .rst_flag (rst_flag)
);

// File: tb/watchdog_unit_test.sv
`timescale 1ns/1ps
module watchdog_unit_test;

  localparam int BL  = 2;
  localparam int NC  = 4;
  localparam int RPW = 3;

  logic       clk = 1'b0;
  logic       rst_n, tick, kick, ctrl_we, wr_irq_en, wr_rst_en;
  logic [3:0] wr_psel;
  logic       irq_clr, flag_we, flag_wdata, lock;
  logic       irq_en, rst_en, irq_pend, wd_reset, rst_flag;
  logic [3:0] psel;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  watchdog_unit #(.BASE_LOG(BL), .NUM_CODES(NC), .RST_PULSE(RPW)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick), .ctrl_we(ctrl_we),
    .wr_irq_en(wr_irq_en), .wr_rst_en(wr_rst_en), .wr_psel(wr_psel),
    .irq_clr(irq_clr), .flag_we(flag_we), .flag_wdata(flag_wdata), .lock(lock),
    .irq_en(irq_en), .rst_en(rst_en), .psel(psel), .irq_pend(irq_pend),
    .wd_reset(wd_reset), .rst_flag(rst_flag)
  );

  function automatic int period(input int code);
    int c;
    c = (code > NC - 1) ? NC - 1 : code;
    return 1 << (BL + c);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic wr_ctrl(input logic ie, input logic re, input logic [3:0] p);
    ctrl_we = 1'b1; wr_irq_en = ie; wr_rst_en = re; wr_psel = p;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic do_kick();
    kick = 1'b1; @(negedge clk); kick = 1'b0;
  endtask

  task automatic clr_irq();
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic wr_flag(input logic v);
    flag_we = 1'b1; flag_wdata = v; @(negedge clk); flag_we = 1'b0;
  endtask

  // one terminal tick, then count high samples of wd_reset
  task automatic pulse_len(output int n);
    n = 0;
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (wd_reset) n++;
      @(negedge clk);
    end
  endtask

  task automatic por();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; tick = 0; kick = 0; ctrl_we = 0; wr_irq_en = 0; wr_rst_en = 0;
    wr_psel = 0; irq_clr = 0; flag_we = 0; flag_wdata = 0; lock = 0;
    @(negedge clk);
    por();

    // R10 reset state
    check("R10 irq_en", irq_en, 0);
    check("R10 rst_en", rst_en, 0);
    check("R10 psel", psel, 0);
    check("R10 irq_pend", irq_pend, 0);
    check("R10 wd_reset", wd_reset, 0);
    check("R10 rst_flag", rst_flag, 0);

    // R7 disabled: no events
    ticks(80);
    check("R7 irq_pend", irq_pend, 0);
    check("R7 wd_reset", wd_reset, 0);

    // R1/R2 sweep of all selector codes, interrupt only (R4)
    for (int code = 0; code < 16; code++) begin
      wr_ctrl(1'b1, 1'b0, 4'(code));
      do_kick();
      ticks(period(code) - 1);
      check(code < NC ? "R1 early" : "R2 early", irq_pend, 0);
      ticks(1);
      check(code < NC ? "R1 expire" : "R2 expire", irq_pend, 1);
      check("R4 no reset", wd_reset, 0);
      ticks(3);
      check("R4 pending held", irq_pend, 1);
      clr_irq();
      check("R4 cleared", irq_pend, 0);
    end

    // R3 kick restarts
    wr_ctrl(1'b1, 1'b0, 4'd1);
    do_kick();
    ticks(7); do_kick(); ticks(7);
    check("R3 kick mid", irq_pend, 0);
    ticks(1);
    check("R3 full period", irq_pend, 1);
    clr_irq();
    ticks(7);
    tick = 1'b1; kick = 1'b1; @(negedge clk); tick = 1'b0; kick = 1'b0; @(negedge clk);
    check("R3 kick on terminal", irq_pend, 0);
    ticks(7);
    check("R3 after terminal kick", irq_pend, 0);
    ticks(1);
    check("R3 expire after kick", irq_pend, 1);
    clr_irq();

    // R5 reset only, pulse width and restart
    for (int code = 0; code < NC; code++) begin
      wr_ctrl(1'b0, 1'b1, 4'(code));
      do_kick();
      ticks(period(code) - 1);
      check("R5 early", wd_reset, 0);
      pulse_len(n);
      check("R5 pulse width", n, RPW);
      check("R5 no irq", irq_pend, 0);
      check("R9 flag set", rst_flag, 1);
    end
    // ticks during the pulse are not counted
    wr_ctrl(1'b0, 1'b1, 4'd0);
    do_kick();
    ticks(3);
    tick = 1'b1; @(negedge clk);
    check("R5 pulse start", wd_reset, 1);
    ticks(1);
    check("R5 pulse mid", wd_reset, 1);
    @(negedge clk);
    ticks(3);
    check("R5 restart early", wd_reset, 0);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    check("R5 restart expire", wd_reset, 1);
    repeat (RPW + 1) @(negedge clk);

    // R9 flag writes and power-on
    wr_flag(1'b1);
    check("R9 write one", rst_flag, 1);
    wr_flag(1'b0);
    check("R9 write zero", rst_flag, 0);
    do_kick();
    ticks(3); pulse_len(n);
    check("R9 set again", rst_flag, 1);
    por();
    check("R9 power-on clear", rst_flag, 0);

    // R6 combined mode
    wr_ctrl(1'b1, 1'b1, 4'd1);
    do_kick();
    ticks(8);
    check("R6 irq first", irq_pend, 1);
    check("R6 irq_en cleared", irq_en, 0);
    check("R6 rst_en kept", rst_en, 1);
    check("R6 no reset yet", wd_reset, 0);
    clr_irq();
    ticks(7);
    check("R6 second early", wd_reset, 0);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    check("R6 second reset", wd_reset, 1);
    check("R6 no second irq", irq_pend, 0);
    repeat (RPW + 1) @(negedge clk);
    wr_ctrl(1'b1, 1'b1, 4'd1);
    do_kick();
    ticks(8);
    check("R6 rearmed irq", irq_pend, 1);
    check("R6 rearmed no reset", wd_reset, 0);
    clr_irq();

    // R8 lock
    lock = 1'b1; @(negedge clk);
    check("R8 irq_en forced", irq_en, 0);
    check("R8 rst_en forced", rst_en, 1);
    wr_ctrl(1'b1, 1'b0, 4'd0);
    check("R8 irq_en after write", irq_en, 0);
    check("R8 rst_en after write", rst_en, 1);
    check("R8 psel writable", psel, 0);
    do_kick();
    ticks(3);
    pulse_len(n);
    check("R8 reset width", n, RPW);
    check("R8 no irq", irq_pend, 0);
    lock = 1'b0; @(negedge clk);
    check("R8 stored irq_en", irq_en, 0);
    check("R8 stored rst_en", rst_en, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule